// File: doc/BRIEF.md
# MAC Engine Enable and Interrupt Control

This block is the control register slice that sits beside a MAC datapath. It starts and stops three engines (transmit, receive and statistics) and collects the event pulses those engines raise into one maskable interrupt line. Software reaches it through a plain register port: a 2-bit word address, 16-bit write data with a write strobe, and 16-bit read data that follows the address combinationally.

Engines are not controlled through a read/write bit. Each engine has its own set strobe and clear strobe in the command word. These strobes take effect once and are not stored. A separate read-only bit in the same word shows whether the engine is running. A second word holds four static link options that drive pins directly. The interrupt status word latches event pulses until software clears them by writing ones. The interrupt enable word selects which pending causes reach the summary bit and the interrupt output.

Top module: `mac_engine_ctl`

## Requirements
- R1: After reset the engine outputs, the option pins and `irq_o` are 0, and all four registers read 0.
- R2: Register map: address 0 is the command word, 1 the option word, 2 the interrupt status word and 3 the interrupt enable word. A write is sampled at a rising edge and shows on readback and on the outputs right after that edge.
- R3: In the command word, a write with bit 5, bit 8 or bit 11 set starts the statistics, transmit or receive engine respectively. The engine output then goes to 1 and the matching status bit reads 1: bit 7 (0x0080) for statistics, bit 10 (0x0400) for transmit, bit 13 (0x2000) for receive. Engines whose strobes are 0 keep their state.
- R4: Bit 6, bit 9 or bit 12 of a command write stops the statistics, transmit or receive engine. If an engine's start and stop strobes are written together, the engine stops.
- R5: The strobe bits and all other command bits, apart from the three status bits, always read 0.
- R6: The option word stores bit 5 (full duplex), bit 6 (large-frame receive), bit 8 (flow control) and bit 9 (keep received CRC) and drives one pin from each. Its other bits read 0.
- R7: A 1 on event input k (k = 0..9) sets status bit k+1 from the following edge on. The causes are: 0x0002 bus error, 0x0004 transmit done, 0x0008 MAC control, 0x0010 receive done, 0x0020 receive start, 0x0040 driver request, 0x0080 statistics near full, 0x0100 link change, 0x0200 transmit DMA done, 0x0400 receive DMA done.
- R8: Writing the status word clears each cause bit written as 1. Bits written as 0, and bit 0, are unaffected by the write.
- R9: If an event pulse and a write-one-to-clear hit the same cause bit in the same cycle, the bit stays set.
- R10: The enable word stores bits 1 to 10 and reads back only those bits. Writing 0 to it masks every cause.
- R11: Status bit 0 reads as the OR of all pending causes whose enable bit is set. `irq_o` equals that summary bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| ev_i | input | 10 | Event pulses; bit k sets status bit k+1 |
| stats_en_o | output | 1 | Statistics engine running |
| tx_en_o | output | 1 | Transmit engine running |
| rx_en_o | output | 1 | Receive engine running |
| full_duplex_o | output | 1 | Full duplex option |
| big_frame_o | output | 1 | Large-frame receive option |
| flow_ctrl_o | output | 1 | Flow control option |
| keep_crc_o | output | 1 | Keep received CRC option |
| irq_o | output | 1 | Interrupt request |

## Verification
A write or an event pulse is applied while the clock is low and is captured at the next rising edge. Its effect on stored state, the engine outputs and the option pins is therefore due in the low phase that follows that edge. Readback and `irq_o` are combinational from stored state, so an address or mask change shows in the same low phase it is applied. The driver applies each stimulus at a falling edge and queues the expected value. The monitor compares one nanosecond after the next falling edge, well clear of any rising edge. The collision case drives the clear write and the pulse in one and the same cycle.

// File: rtl/mac_engine_ctl_pkg.sv
package mac_engine_ctl_pkg;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned ADDR_W     = 2;
  localparam int unsigned NUM_CAUSES = 10;
  localparam int unsigned NUM_ENG    = 3;

  // register word addresses
  localparam logic [ADDR_W-1:0] A_CMD = 2'd0;
  localparam logic [ADDR_W-1:0] A_OPT = 2'd1;
  localparam logic [ADDR_W-1:0] A_IST = 2'd2;
  localparam logic [ADDR_W-1:0] A_IEN = 2'd3;

  // engine strobe groups: start at base, stop at base+1, status at base+2
  localparam int unsigned ENG_STATS = 0;
  localparam int unsigned ENG_TX    = 1;
  localparam int unsigned ENG_RX    = 2;

  function automatic int unsigned eng_base(int unsigned idx);
    return 5 + 3 * idx;
  endfunction

  // option word stored bits
  localparam logic [DATA_W-1:0] OPT_MASK = 16'h0360;
  localparam int unsigned OPT_FDX  = 5;
  localparam int unsigned OPT_BIG  = 6;
  localparam int unsigned OPT_FLOW = 8;
  localparam int unsigned OPT_CRC  = 9;
endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/mac_eng_switch.sv
module mac_eng_switch (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic start_stb,
  input  logic stop_stb,
  output logic running
);
  logic run_d, run_q;

  always_comb begin
    run_d = run_q;
    if (cmd_wr) begin
      if (stop_stb)       run_d = 1'b0;
      else if (start_stb) run_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assign running = run_q;

  // R4: a stop strobe always ends with the engine stopped
  a_r4_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && stop_stb) |=> !running);
  // R3: a lone start strobe leaves the engine running
  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && start_stb && !stop_stb) |=> running);
  // R3: without a command write the engine state holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(running));
endmodule

// File: rtl/mac_opt_reg.sv
module mac_opt_reg #(
  parameter int unsigned          W    = 16,
  parameter logic [W-1:0]         MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] d, q_r;

  always_comb begin
    d = q_r;
    if (wr) d = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= d;
  end

  assign q = q_r;

  // R6: a write lands masked on the next cycle
  a_r6_opt_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (q == ($past(wdata) & MASK)));
  // R6: unmasked bits never hold a one
  a_r6_opt_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~MASK) == '0);
endmodule

// File: rtl/mac_irq_unit.sv
module mac_irq_unit #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         st_wr,
  input  logic         en_wr,
  input  logic [N-1:0] wcause,
  output logic [N-1:0] pending,
  output logic [N-1:0] enabled,
  output logic         summary
);
  logic [N-1:0] st_d, st_q, en_d, en_q, clr;

  always_comb begin
    clr  = st_wr ? wcause : '0;
    st_d = (st_q & ~clr) | ev;
    en_d = en_wr ? wcause : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= st_d;
      en_q <= en_d;
    end
  end

  assign pending = st_q;
  assign enabled = en_q;
  assign summary = |(st_q & en_q);

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_cause
      // R7 and R9: a pulse sets its bit, even against a same-cycle clear
      a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev[k] |=> st_q[k]);
      // R8: a one written without a pulse clears the bit
      a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && wcause[k] && !ev[k]) |=> !st_q[k]);
    end
  endgenerate

  // R10: with nothing enabled the summary stays low
  a_r10_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !summary);
  // R11: a raised summary needs a pending enabled cause
  a_r11_summary_src: assert property (@(posedge clk) disable iff (!rst_n)
    summary |-> ((st_q != '0) && (en_q != '0)));
endmodule

// File: rtl/mac_engine_ctl.sv
module mac_engine_ctl
  import mac_engine_ctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NUM_CAUSES-1:0] ev_i,
  output logic                  stats_en_o,
  output logic                  tx_en_o,
  output logic                  rx_en_o,
  output logic                  full_duplex_o,
  output logic                  big_frame_o,
  output logic                  flow_ctrl_o,
  output logic                  keep_crc_o,
  output logic                  irq_o
);
  localparam int unsigned CAUSE_LO = 1;
  localparam int unsigned CAUSE_HI = CAUSE_LO + NUM_CAUSES - 1;

  logic rst_i_n;
  logic cmd_wr, opt_wr, ist_wr, ien_wr;
  logic [NUM_ENG-1:0] eng_on;
  logic [DATA_W-1:0] opt_q, cmd_rd, ist_rd, ien_rd;
  logic [NUM_CAUSES-1:0] pend, enab;
  logic summ;

  mac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // address decode
  always_comb begin
    cmd_wr = reg_we && (reg_addr == A_CMD);
    opt_wr = reg_we && (reg_addr == A_OPT);
    ist_wr = reg_we && (reg_addr == A_IST);
    ien_wr = reg_we && (reg_addr == A_IEN);
  end

  genvar e;
  generate
    for (e = 0; e < NUM_ENG; e++) begin : g_eng
      mac_eng_switch u_sw (
        .clk       (clk),
        .rst_n     (rst_i_n),
        .cmd_wr    (cmd_wr),
        .start_stb (reg_wdata[eng_base(e)]),
        .stop_stb  (reg_wdata[eng_base(e) + 1]),
        .running   (eng_on[e])
      );
    end
  endgenerate

  mac_opt_reg #(.W(DATA_W), .MASK(OPT_MASK)) u_opt (
    .clk   (clk),
    .rst_n (rst_i_n),
    .wr    (opt_wr),
    .wdata (reg_wdata),
    .q     (opt_q)
  );

  mac_irq_unit #(.N(NUM_CAUSES)) u_irq (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .ev      (ev_i),
    .st_wr   (ist_wr),
    .en_wr   (ien_wr),
    .wcause  (reg_wdata[CAUSE_HI:CAUSE_LO]),
    .pending (pend),
    .enabled (enab),
    .summary (summ)
  );

  // readback words
  always_comb begin
    cmd_rd = '0;
    for (int i = 0; i < NUM_ENG; i++) cmd_rd[eng_base(i) + 2] = eng_on[i];
    ist_rd = '0;
    ist_rd[CAUSE_HI:CAUSE_LO] = pend;
    ist_rd[0] = summ;
    ien_rd = '0;
    ien_rd[CAUSE_HI:CAUSE_LO] = enab;
  end

  always_comb begin
    unique case (reg_addr)
      A_CMD:   reg_rdata = cmd_rd;
      A_OPT:   reg_rdata = opt_q;
      A_IST:   reg_rdata = ist_rd;
      default: reg_rdata = ien_rd;
    endcase
  end

  assign stats_en_o    = eng_on[ENG_STATS];
  assign tx_en_o       = eng_on[ENG_TX];
  assign rx_en_o       = eng_on[ENG_RX];
  assign full_duplex_o = opt_q[OPT_FDX];
  assign big_frame_o   = opt_q[OPT_BIG];
  assign flow_ctrl_o   = opt_q[OPT_FLOW];
  assign keep_crc_o    = opt_q[OPT_CRC];
  assign irq_o         = summ;

  // R5: command readback never shows a strobe bit
  a_r5_strobes_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_rd & 16'hDB7F) == '0);
  // R2: a write to one register leaves the engine set alone
  a_r2_cmd_isolated: assert property (@(posedge clk) disable iff (!rst_i_n)
    (reg_we && reg_addr != A_CMD) |=> $stable(eng_on));
endmodule

// File: tb/mac_engine_ctl_bench.sv
module mac_engine_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [9:0]  ev_i;
  logic stats_en_o, tx_en_o, rx_en_o;
  logic full_duplex_o, big_frame_o, flow_ctrl_o, keep_crc_o, irq_o;

  always #2.5ns clk = ~clk;

  mac_engine_ctl u_mac_engine_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_i(ev_i),
    .stats_en_o(stats_en_o), .tx_en_o(tx_en_o), .rx_en_o(rx_en_o),
    .full_duplex_o(full_duplex_o), .big_frame_o(big_frame_o),
    .flow_ctrl_o(flow_ctrl_o), .keep_crc_o(keep_crc_o), .irq_o(irq_o)
  );

  // sel: 0 readback, 1 irq pin, 2 engine pins {stats,tx,rx}, 3 option pins {crc,flow,big,fdx}
  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic expect_item(int sel, logic [1:0] addr, logic [15:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    reg_addr = addr;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] addr, logic [15:0] d);
    reg_we = 1'b1; reg_addr = addr; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(logic [9:0] e);
    ev_i = e;
    @(negedge clk);
    ev_i = '0;
  endtask

  task automatic wr_pulse(logic [1:0] addr, logic [15:0] d, logic [9:0] e);
    reg_we = 1'b1; reg_addr = addr; reg_wdata = d; ev_i = e;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; ev_i = '0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1ns;
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        case (it.sel)
          0:       act = reg_rdata;
          1:       act = {15'd0, irq_o};
          2:       act = {13'd0, stats_en_o, tx_en_o, rx_en_o};
          default: act = {12'd0, keep_crc_o, flow_ctrl_o, big_frame_o, full_duplex_o};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got 0x%04h expected 0x%04h", it.tag, act, it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; ev_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    expect_item(0, 2'd0, 16'h0000, "R1 cmd");
    expect_item(0, 2'd1, 16'h0000, "R1 opt");
    expect_item(0, 2'd2, 16'h0000, "R1 status");
    expect_item(0, 2'd3, 16'h0000, "R1 enable");
    expect_item(1, 2'd0, 16'h0000, "R1 irq");
    expect_item(2, 2'd0, 16'h0000, "R1 engines");
    expect_item(3, 2'd0, 16'h0000, "R1 options");

    // R3 starts, R5 strobes read zero, R2 timing after one edge
    wr(2'd0, 16'h0100);
    expect_item(0, 2'd0, 16'h0400, "R3 R5 tx start readback");
    expect_item(2, 2'd0, 16'h0002, "R2 tx pin");
    wr(2'd0, 16'h0820);
    expect_item(0, 2'd0, 16'h2480, "R3 rx and stats start");
    expect_item(2, 2'd0, 16'h0007, "R3 all pins");
    // R4 stop
    wr(2'd0, 16'h0200);
    expect_item(0, 2'd0, 16'h2080, "R4 tx stop");
    // R4 start+stop together: stop wins
    wr(2'd0, 16'h1800);
    expect_item(0, 2'd0, 16'h0080, "R4 rx both strobes");
    wr(2'd0, 16'h0060);
    expect_item(2, 2'd0, 16'h0000, "R4 stats both strobes");
    // R5 writing status bits directly does nothing
    wr(2'd0, 16'h2480);
    expect_item(0, 2'd0, 16'h0000, "R5 status bits not writable");

    // R6 options
    wr(2'd1, 16'hFFFF);
    expect_item(0, 2'd1, 16'h0360, "R6 opt all ones");
    expect_item(3, 2'd0, 16'h000F, "R6 opt pins");
    wr(2'd1, 16'h0120);
    expect_item(3, 2'd0, 16'h0005, "R6 fdx+flow pins");
    expect_item(2, 2'd0, 16'h0000, "R2 opt write leaves engines");

    // R7 event latch, masked
    pulse(10'b00_0000_0010);
    expect_item(0, 2'd2, 16'h0004, "R7 tx done latched");
    expect_item(1, 2'd0, 16'h0000, "R10 masked irq");
    // R11 enable it
    wr(2'd3, 16'h0004);
    expect_item(0, 2'd2, 16'h0005, "R11 summary bit");
    expect_item(1, 2'd0, 16'h0001, "R11 irq high");
    wr(2'd3, 16'hFFFF);
    expect_item(0, 2'd3, 16'h07FE, "R10 enable readback");
    // R8 clear
    wr(2'd2, 16'h0004);
    expect_item(0, 2'd2, 16'h0000, "R8 cleared");
    expect_item(1, 2'd0, 16'h0000, "R11 irq low after clear");
    // several causes
    pulse(10'b10_1000_0001);
    expect_item(0, 2'd2, 16'h0503, "R7 multi cause");
    // R10 zero masks all
    wr(2'd3, 16'h0000);
    expect_item(1, 2'd0, 16'h0000, "R10 zero masks irq");
    expect_item(0, 2'd2, 16'h0502, "R10 status kept");
    // R9 collision
    wr_pulse(2'd2, 16'h0100, 10'b00_1000_0000);
    expect_item(0, 2'd2, 16'h0502, "R9 pulse beats clear");
    // R8 zeros and bit0 unaffected
    wr(2'd2, 16'h0001);
    expect_item(0, 2'd2, 16'h0502, "R8 bit0 write ignored");
    wr(2'd2, 16'h0402);
    expect_item(0, 2'd2, 16'h0100, "R8 partial clear");
    wr(2'd3, 16'h0100);
    expect_item(1, 2'd0, 16'h0001, "R11 link irq");

    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule